// File: doc/BRIEF.md
# DMA Channel Command and State Controller

This block is the control and status front end of one DMA channel. The channel can be a descriptor-transfer channel or a completion-event channel. Software writes an 8-bit command into bits 23:16 of the control word at offset 0x000, and reads the channel's current state back from bits 15:8 of the same word. The data-moving engine sits outside the block. It signals in-flight work on `eng_busy`, reports each retired descriptor on `eng_consume`, and raises `eng_error` on a fault. In return, `eng_fetch_en` tells it when it may start new descriptors.

Software posts new work by writing the producer byte offset of the descriptor ring into the doorbell at offset 0x400. The block keeps its own consumer offset, readable at 0x404. The channel is running while the two offsets differ or while the engine is still busy, and it drops back to enabled once the ring is drained and the engine is idle. The block also holds the ring base (low word at 0x008, high word at 0x00C), the ring length in bytes (0x010) and a quiesce cycle count (0x018).

The reported state codes are disabled 0, enabled 1, running 2, suspended 3 and stopped 4. The internal machine has seven states:
- OFF reports 0.
- READY reports 1.
- ACTIVE reports 2.
- DRAIN is a suspend that waits for in-flight work, and reports 2.
- PAUSED reports 3.
- HALTED reports 4.
- QUIESCE is a reset in progress, and reports 3.

The transitions are:
- OFF→READY/ACTIVE on enable.
- READY→ACTIVE when work is pending.
- ACTIVE→READY when the ring is drained and the engine is idle.
- READY/ACTIVE→DRAIN or PAUSED on suspend.
- DRAIN→PAUSED when the engine goes idle.
- DRAIN/PAUSED→READY/ACTIVE on enable.
- Any operational state→OFF on disable.
- Any state but QUIESCE→HALTED on error.
- Any state→QUIESCE on reset.
- QUIESCE→OFF after the quiesce count.

Top module: `dmach_ctl`

## Requirements
- R1: After reset the state code is 0, the producer and consumer offsets read 0, the ring registers read 0, the quiesce register reads its default of 4, and `eng_fetch_en` is 0.
- R2: Command codes in bits 23:16 are disable 0, enable 1, suspend 2 and reset 9. An enable written while the state is 0 gives state 1 on the next cycle when no work is pending. The state field only ever takes values 0 to 4.
- R3: While enabled, a doorbell value that differs from the consumer offset moves the state to 2 and raises `eng_fetch_en`. The state returns to 1 only once the offsets are equal and `eng_busy` is low.
- R4: Each `eng_consume` pulse in a running state advances the consumer offset by 16 bytes, wrapping to (offset + 16 − ring length) when the sum reaches the ring length. The offset does not move otherwise.
- R5: A suspend with `eng_busy` high keeps reporting 2 until busy falls, and the state becomes 3 on the following cycle. A suspend with the engine idle gives 3 directly.
- R6: A reset command reports 3 for (quiesce count + 1) idle cycles, and stays there while the engine is busy. It then reports 0, with the producer and consumer offsets both zeroed.
- R7: An `eng_error` pulse forces state 4. Enable, disable and suspend are then ignored, and only a reset command leaves state 4.
- R8: A command code outside {0,1,2,9} leaves the state unchanged. Bits 23:16 of the control word read back the last command code written.
- R9: Disable moves enabled, running or suspended states to 0 on the next cycle and leaves both ring offsets unchanged.
- R10: The ring base low, base high, length and quiesce registers read back the values written.
- R11: Enable from the suspended state resumes at 2 when work is pending, or at 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | AW (11) | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | AW (11) | Register read byte offset |
| reg_rd_data | output | 32 | Combinational read data |
| eng_busy | input | 1 | Engine has a transfer in flight |
| eng_consume | input | 1 | Engine retired one descriptor |
| eng_error | input | 1 | Engine fault |
| eng_fetch_en | output | 1 | Engine may start new descriptors |
| chan_state | output | 8 | Current state code (same as control bits 15:8) |

## Verification
A write to the control word, or a consume pulse, is captured at one clock edge, and the new state is visible right after that edge. A doorbell write is the exception: it updates the producer offset at the capturing edge, and the change to running follows one edge later. Reaching idle through a consume behaves the same way, with the return to enabled one edge after the offset becomes equal. A reset is due (quiesce + 1) edges after the command edge. The bench drives on falling edges and samples 1 ns after a falling edge. Each table step writes, waits one more edge, and then compares. The directed tests count the edges for the drain, quiesce and wrap cases before each sample.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int REG_W = 32;

    // register byte offsets
    localparam int OFS_CTRL     = 'h000;
    localparam int OFS_BASE_LO  = 'h008;
    localparam int OFS_BASE_HI  = 'h00C;
    localparam int OFS_LEN      = 'h010;
    localparam int OFS_QUIESCE  = 'h018;
    localparam int OFS_DOORBELL = 'h400;
    localparam int OFS_CONSUMER = 'h404;

    // command codes (control word bits 23:16)
    localparam logic [7:0] CMD_DISABLE = 8'd0;
    localparam logic [7:0] CMD_ENABLE  = 8'd1;
    localparam logic [7:0] CMD_SUSPEND = 8'd2;
    localparam logic [7:0] CMD_RESET   = 8'd9;

    // reported state codes (control word bits 15:8)
    localparam logic [7:0] CODE_DISABLED  = 8'd0;
    localparam logic [7:0] CODE_ENABLED   = 8'd1;
    localparam logic [7:0] CODE_RUNNING   = 8'd2;
    localparam logic [7:0] CODE_SUSPENDED = 8'd3;
    localparam logic [7:0] CODE_STOPPED   = 8'd4;

    typedef enum logic [2:0] {
        S_OFF,
        S_READY,
        S_ACTIVE,
        S_DRAIN,
        S_PAUSED,
        S_HALTED,
        S_QUIESCE
    } fsm_e;

    typedef struct packed {
        logic en;
        logic dis;
        logic susp;
        logic rst;
    } cmd_t;

endpackage

// File: rtl/dmach_cmd_decode.sv
module dmach_cmd_decode
    import dmach_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    code_in,
    output cmd_t          cmd,
    output logic          ctrl_wr,
    output logic          db_wr
);

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == AW'(OFS_CTRL));
        db_wr   = wr_en && (wr_addr == AW'(OFS_DOORBELL));
        cmd     = '0;
        if (ctrl_wr) begin
            unique case (code_in)
                CMD_DISABLE: cmd.dis  = 1'b1;
                CMD_ENABLE:  cmd.en   = 1'b1;
                CMD_SUSPEND: cmd.susp = 1'b1;
                CMD_RESET:   cmd.rst  = 1'b1;
                default:     cmd      = '0;   // unknown code: no action
            endcase
        end
    end

endmodule

// File: rtl/dmach_fsm.sv
module dmach_fsm
    import dmach_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_t          cmd,
    input  logic          pending,
    input  logic          busy,
    input  logic          hw_err,
    input  logic [QW-1:0] quiesce,
    output logic [7:0]    state_code,
    output logic          fetch_en,
    output logic          consume_ok,
    output logic          rst_done
);

    fsm_e          st, nxt;
    logic [QW-1:0] qcnt;
    logic          any_cmd;

    assign any_cmd = cmd.en | cmd.dis | cmd.susp | cmd.rst;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_OFF;
        else        st <= nxt;
    end

    // quiesce counter: counts idle cycles spent in QUIESCE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  qcnt <= '0;
        else if (st != S_QUIESCE || cmd.rst || busy) qcnt <= '0;
        else if (qcnt < quiesce)                     qcnt <= qcnt + 1'b1;
    end

    // next state
    always_comb begin
        nxt = st;
        if (cmd.rst) begin
            nxt = S_QUIESCE;
        end else if (st == S_QUIESCE) begin
            if (!busy && qcnt >= quiesce) nxt = S_OFF;
        end else if (hw_err) begin
            nxt = S_HALTED;
        end else begin
            unique case (st)
                S_OFF: begin
                    if (cmd.en) nxt = pending ? S_ACTIVE : S_READY;
                end
                S_READY: begin
                    if (cmd.dis)       nxt = S_OFF;
                    else if (cmd.susp) nxt = busy ? S_DRAIN : S_PAUSED;
                    else if (pending)  nxt = S_ACTIVE;
                end
                S_ACTIVE: begin
                    if (cmd.dis)               nxt = S_OFF;
                    else if (cmd.susp)         nxt = busy ? S_DRAIN : S_PAUSED;
                    else if (!pending && !busy) nxt = S_READY;
                end
                S_DRAIN: begin
                    if (cmd.dis)     nxt = S_OFF;
                    else if (cmd.en) nxt = pending ? S_ACTIVE : S_READY;
                    else if (!busy)  nxt = S_PAUSED;
                end
                S_PAUSED: begin
                    if (cmd.dis)     nxt = S_OFF;
                    else if (cmd.en) nxt = pending ? S_ACTIVE : S_READY;
                end
                S_HALTED: nxt = S_HALTED;
                default:  nxt = S_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            S_OFF:     state_code = CODE_DISABLED;
            S_READY:   state_code = CODE_ENABLED;
            S_ACTIVE:  state_code = CODE_RUNNING;
            S_DRAIN:   state_code = CODE_RUNNING;
            S_PAUSED:  state_code = CODE_SUSPENDED;
            S_HALTED:  state_code = CODE_STOPPED;
            S_QUIESCE: state_code = CODE_SUSPENDED;
            default:   state_code = CODE_DISABLED;
        endcase
        fetch_en   = (st == S_ACTIVE);
        consume_ok = (st == S_ACTIVE) || (st == S_DRAIN);
        rst_done   = (st == S_QUIESCE) && (nxt == S_OFF);
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HALTED && !cmd.rst) |=> (st == S_HALTED)); // R7

    AST_DRAIN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DRAIN && busy && !hw_err && !any_cmd) |=> (st == S_DRAIN)); // R5

    AST_WORK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_READY && pending && !hw_err && !any_cmd) |=> (st == S_ACTIVE)); // R3

    AST_QUIESCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_QUIESCE && busy) |=> (st == S_QUIESCE)); // R6

endmodule

// File: rtl/dmach_ring_ptrs.sv
module dmach_ring_ptrs #(
    parameter int OW         = 16,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          db_wr,
    input  logic [OW-1:0] db_data,
    input  logic          consume,
    input  logic          consume_ok,
    input  logic [OW-1:0] ring_len,
    input  logic          clear,
    output logic [OW-1:0] prod,
    output logic [OW-1:0] cons,
    output logic          pending
);

    localparam logic [OW:0] STEP = (OW+1)'(DESC_BYTES);

    logic [OW:0] sum, wrapped;

    always_comb begin
        sum     = {1'b0, cons} + STEP;
        wrapped = (sum >= {1'b0, ring_len}) ? (sum - {1'b0, ring_len}) : sum;
        pending = (prod != cons);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod <= '0;
            cons <= '0;
        end else if (clear) begin
            prod <= '0;
            cons <= '0;
        end else begin
            if (db_wr)                 prod <= db_data;
            if (consume && consume_ok) cons <= wrapped[OW-1:0];
        end
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (prod == '0 && cons == '0)); // R6

    AST_CONS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(consume && consume_ok)) |=> $stable(cons)); // R4

endmodule

// File: rtl/dmach_regfile.sv
module dmach_regfile
    import dmach_pkg::*;
#(
    parameter int AW       = 11,
    parameter int OW       = 16,
    parameter int QW       = 16,
    parameter int QDEFAULT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ctrl_wr,
    input  logic [AW-1:0]    rd_addr,
    input  logic [7:0]       state_code,
    input  logic [OW-1:0]    prod,
    input  logic [OW-1:0]    cons,
    output logic [OW-1:0]    ring_len,
    output logic [QW-1:0]    quiesce,
    output logic [REG_W-1:0] rd_data
);

    logic [REG_W-1:0] base_lo, base_hi;
    logic [7:0]       last_cmd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_lo  <= '0;
            base_hi  <= '0;
            ring_len <= '0;
            quiesce  <= QW'(QDEFAULT);
            last_cmd <= '0;
        end else begin
            if (ctrl_wr) last_cmd <= wr_data[23:16];
            if (wr_en) begin
                if (wr_addr == AW'(OFS_BASE_LO)) base_lo  <= wr_data;
                if (wr_addr == AW'(OFS_BASE_HI)) base_hi  <= wr_data;
                if (wr_addr == AW'(OFS_LEN))     ring_len <= wr_data[OW-1:0];
                if (wr_addr == AW'(OFS_QUIESCE)) quiesce  <= wr_data[QW-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(OFS_CTRL))     rd_data = {8'h00, last_cmd, state_code, 8'h00};
        if (rd_addr == AW'(OFS_BASE_LO))  rd_data = base_lo;
        if (rd_addr == AW'(OFS_BASE_HI))  rd_data = base_hi;
        if (rd_addr == AW'(OFS_LEN))      rd_data = REG_W'(ring_len);
        if (rd_addr == AW'(OFS_QUIESCE))  rd_data = REG_W'(quiesce);
        if (rd_addr == AW'(OFS_DOORBELL)) rd_data = REG_W'(prod);
        if (rd_addr == AW'(OFS_CONSUMER)) rd_data = REG_W'(cons);
    end

endmodule

// File: rtl/dmach_ctl.sv
module dmach_ctl
    import dmach_pkg::*;
#(
    parameter int AW         = 11,
    parameter int OW         = 16,
    parameter int QW         = 16,
    parameter int DESC_BYTES = 16,
    parameter int QDEFAULT   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [AW-1:0]    reg_wr_addr,
    input  logic [REG_W-1:0] reg_wr_data,
    input  logic [AW-1:0]    reg_rd_addr,
    output logic [REG_W-1:0] reg_rd_data,
    input  logic             eng_busy,
    input  logic             eng_consume,
    input  logic             eng_error,
    output logic             eng_fetch_en,
    output logic [7:0]       chan_state
);

    cmd_t          cmd;
    logic          ctrl_wr, db_wr;
    logic          pending, consume_ok, rst_done;
    logic [OW-1:0] prod, cons, ring_len;
    logic [QW-1:0] quiesce;

    dmach_cmd_decode #(.AW(AW)) u_dec (
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .code_in (reg_wr_data[23:16]),
        .cmd     (cmd),
        .ctrl_wr (ctrl_wr),
        .db_wr   (db_wr)
    );

    dmach_fsm #(.QW(QW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .pending    (pending),
        .busy       (eng_busy),
        .hw_err     (eng_error),
        .quiesce    (quiesce),
        .state_code (chan_state),
        .fetch_en   (eng_fetch_en),
        .consume_ok (consume_ok),
        .rst_done   (rst_done)
    );

    dmach_ring_ptrs #(.OW(OW), .DESC_BYTES(DESC_BYTES)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .db_wr      (db_wr),
        .db_data    (reg_wr_data[OW-1:0]),
        .consume    (eng_consume),
        .consume_ok (consume_ok),
        .ring_len   (ring_len),
        .clear      (rst_done),
        .prod       (prod),
        .cons       (cons),
        .pending    (pending)
    );

    dmach_regfile #(.AW(AW), .OW(OW), .QW(QW), .QDEFAULT(QDEFAULT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_addr    (reg_wr_addr),
        .wr_data    (reg_wr_data),
        .ctrl_wr    (ctrl_wr),
        .rd_addr    (reg_rd_addr),
        .state_code (chan_state),
        .prod       (prod),
        .cons       (cons),
        .ring_len   (ring_len),
        .quiesce    (quiesce),
        .rd_data    (reg_rd_data)
    );

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        chan_state <= CODE_STOPPED); // R2

    AST_FETCH_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        eng_fetch_en |-> (chan_state == CODE_RUNNING)); // R3

endmodule

// File: tb/dmach_ctl_bench.sv
module dmach_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [10:0] reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [10:0] reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        eng_busy = 1'b0;
    logic        eng_consume = 1'b0;
    logic        eng_error = 1'b0;
    logic        eng_fetch_en;
    logic [7:0]  chan_state;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    dmach_ctl u_dmach_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_wr_addr  (reg_wr_addr),
        .reg_wr_data  (reg_wr_data),
        .reg_rd_addr  (reg_rd_addr),
        .reg_rd_data  (reg_rd_data),
        .eng_busy     (eng_busy),
        .eng_consume  (eng_consume),
        .eng_error    (eng_error),
        .eng_fetch_en (eng_fetch_en),
        .chan_state   (chan_state)
    );

    // vector: {addr[12], data[32], busy[1], expected state[8]}
    localparam int NV = 8;
    localparam logic [52:0] VECS [NV] = '{
        {12'h010, 32'd64,         1'b0, 8'd0},  // R10 ring length write
        {12'h000, 32'h0001_0000,  1'b0, 8'd1},  // R2 enable, nothing pending
        {12'h400, 32'd32,         1'b0, 8'd2},  // R3 doorbell -> running
        {12'h000, 32'h0007_0000,  1'b0, 8'd2},  // R8 unknown code ignored
        {12'h000, 32'h0002_0000,  1'b1, 8'd2},  // R5 suspend while busy drains
        {12'h008, 32'h0000_1234,  1'b0, 8'd3},  // R5 drain done -> suspended
        {12'h000, 32'h0001_0000,  1'b0, 8'd2},  // R11 resume with pending work
        {12'h000, 32'h0000_0000,  1'b0, 8'd0}   // R9 disable
    };
    string vtag [NV] = '{"R10", "R2", "R3", "R8", "R5", "R5", "R11", "R9"};

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string what);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", what, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_addr = a[10:0];
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_rd_addr = a[10:0];
        #1;
        d = reg_rd_data;
    endtask

    task automatic pulse_consume();
        @(negedge clk);
        eng_consume = 1'b1;
        @(negedge clk);
        eng_consume = 1'b0;
    endtask

    task automatic state_is(input logic [7:0] exp, input string what);
        logic [31:0] v;
        rd(12'h000, v);
        check({24'h0, v[15:8]}, {24'h0, exp}, what);
        check({24'h0, chan_state}, {24'h0, exp}, what);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        state_is(8'd0, "R1 state after reset");
        rd(12'h018, v); check(v, 32'd4, "R1 quiesce default");
        rd(12'h400, v); check(v, 32'd0, "R1 producer");
        rd(12'h404, v); check(v, 32'd0, "R1 consumer");
        rd(12'h010, v); check(v, 32'd0, "R1 ring length");
        check({31'h0, eng_fetch_en}, 32'd0, "R1 fetch enable");

        // table walk
        for (int i = 0; i < NV; i++) begin
            eng_busy = VECS[i][8];
            wr(VECS[i][52:41], VECS[i][40:9]);
            @(negedge clk);
            state_is(VECS[i][7:0], {vtag[i], " table step"});
            if (i == 2) check({31'h0, eng_fetch_en}, 32'd1, "R3 fetch enable while running");
            if (i == 3) begin
                rd(12'h000, v);
                check({24'h0, v[23:16]}, 32'd7, "R8 last command readback");
            end
        end
        eng_busy = 1'b0;

        // R9 offsets kept by disable, R10 readbacks
        rd(12'h400, v); check(v, 32'd32, "R9 producer kept");
        rd(12'h404, v); check(v, 32'd0,  "R9 consumer kept");
        rd(12'h008, v); check(v, 32'h1234, "R10 base low");
        wr(12'h00C, 32'hCAFE_0001);
        rd(12'h00C, v); check(v, 32'hCAFE_0001, "R10 base high");
        rd(12'h010, v); check(v, 32'd64, "R10 ring length");

        // R6 reset with quiesce 2
        wr(12'h018, 32'd2);
        rd(12'h018, v); check(v, 32'd2, "R10 quiesce readback");
        wr(12'h000, 32'h0009_0000);
        state_is(8'd3, "R6 quiesce first cycle");
        @(negedge clk); @(negedge clk);
        state_is(8'd3, "R6 quiesce last cycle");
        @(negedge clk);
        state_is(8'd0, "R6 disabled after quiesce");
        rd(12'h400, v); check(v, 32'd0, "R6 producer zeroed");

        // R4 consume and wrap
        wr(12'h000, 32'h0001_0000);
        state_is(8'd1, "R2 enable idle");
        wr(12'h400, 32'd48);
        @(negedge clk);
        state_is(8'd2, "R3 running after doorbell");
        for (int k = 0; k < 3; k++) pulse_consume();
        rd(12'h404, v); check(v, 32'd48, "R4 consumer after three");
        @(negedge clk);
        state_is(8'd1, "R3 back to enabled when drained");
        wr(12'h400, 32'd16);
        @(negedge clk);
        pulse_consume();
        rd(12'h404, v); check(v, 32'd0, "R4 consumer wrap");
        eng_busy = 1'b1;
        pulse_consume();
        @(negedge clk);
        state_is(8'd2, "R3 busy holds running");
        eng_busy = 1'b0;
        @(negedge clk);
        state_is(8'd1, "R3 enabled once idle");

        // R7 error
        @(negedge clk); eng_error = 1'b1;
        @(negedge clk); eng_error = 1'b0;
        state_is(8'd4, "R7 stopped on error");
        wr(12'h000, 32'h0001_0000);
        state_is(8'd4, "R7 enable ignored");
        wr(12'h000, 32'h0000_0000);
        state_is(8'd4, "R7 disable ignored");
        wr(12'h018, 32'd0);
        wr(12'h000, 32'h0009_0000);
        state_is(8'd3, "R7 reset leaves stopped");
        @(negedge clk);
        state_is(8'd0, "R6 quiesce zero");

        // R5 idle suspend, R9 disable from suspended, R11 idle resume
        wr(12'h000, 32'h0001_0000);
        wr(12'h000, 32'h0002_0000);
        state_is(8'd3, "R5 idle suspend");
        wr(12'h000, 32'h0001_0000);
        state_is(8'd1, "R11 resume without work");
        wr(12'h000, 32'h0002_0000);
        wr(12'h000, 32'h0000_0000);
        state_is(8'd0, "R9 disable from suspended");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule